// File: doc/BRIEF.md
# Flash Swap Address Remapper

This block sits on the read path between a CPU and a code flash array. It can make the two equal-sized regions at the bottom of the flash address space trade places. The usual purpose is to let a copy of the boot code answer at address zero while the original region is being rewritten. When the swap is released, each region returns to its own address.

Two registered fields hold the configuration. One is a 2-bit swap state. The other is a 6-bit size code. A single load strobe writes both fields, and both are visible on status outputs. Every read address is translated combinationally to a physical array address. Inside the active window, this translation inverts the one address bit whose weight equals the size of one region. Every other address passes through unchanged.

Top module: `flash_swap_remap`

## Requirements
- R1: After reset the state field reads 00, the size field reads 000000, swap_active is low and phys_addr equals cpu_addr.
- R2: When cfg_load is high at a rising clock edge, the state and size fields take cfg_state_in and cfg_size_in. The new values show on the status outputs and in the translation from the following cycle on. While cfg_load is low, both fields hold their values.
- R3: With state 01 and a valid size code, an address in the lower region maps to the same offset in the upper region, and an address in the upper region maps to the same offset in the lower region.
- R4: A size code k in the range 1 to 6 selects regions of 2^(10+k) bytes each. The window therefore spans 2^(11+k) bytes: code 1 gives a 4 KB window, code 2 gives 8 KB, and code 6 gives 128 KB.
- R5: An address at or above the top of the selected window passes through unchanged.
- R6: State codes 00, 10 and 11 leave every address unswapped. Code 11 is the release code: it returns both regions to their own addresses.
- R7: Size code 000000 and any size code from 7 to 63 leave every address unswapped.
- R8: phys_addr differs from cpu_addr in at most one bit position.
- R9: swap_active is high exactly when the state is 01 and the size code lies between 1 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Load strobe for the state and size fields |
| cfg_state_in | input | 2 | New swap state (01 swap, 11 release) |
| cfg_size_in | input | 6 | New swap size code |
| cpu_addr | input | 21 | Read address from the CPU |
| phys_addr | output | 21 | Translated address to the flash array |
| stat_state | output | 2 | Current swap state |
| stat_size | output | 6 | Current swap size code |
| swap_active | output | 1 | Remap currently in force |

## Verification
The bench builds the block with its defaults: a 21-bit address, a 2 KB smallest region and six size codes. Under these values the largest window, 128 KB, sits well below the top of the address space, so addresses above every window can be exercised alongside addresses inside each one. The smallest, a middle and the largest size code are each probed at both regions and at the first address past the window. The undefined size codes, the non-swap state codes and a swap-then-release sequence are also covered. The one-cycle delay between the load strobe and the translation is checked on both sides of the edge.

// File: rtl/flash_swap_remap.sv
module flash_swap_remap #(
  parameter int ADDR_W    = 21,
  parameter int BASE_LOG2 = 11,
  parameter int MAX_CODE  = 6,
  parameter int STATE_W   = 2,
  parameter int SIZE_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [STATE_W-1:0] cfg_state_in,
  input  logic [SIZE_W-1:0]  cfg_size_in,
  input  logic [ADDR_W-1:0]  cpu_addr,
  output logic [ADDR_W-1:0]  phys_addr,
  output logic [STATE_W-1:0] stat_state,
  output logic [SIZE_W-1:0]  stat_size,
  output logic               swap_active
);

  localparam int TOP_BIT = BASE_LOG2 + MAX_CODE;
  localparam logic [STATE_W-1:0] ST_SWAP = STATE_W'(1);

  logic [STATE_W-1:0] state_q;
  logic [SIZE_W-1:0]  size_q;
  logic               code_ok;
  logic [ADDR_W-1:0]  flip_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      size_q  <= '0;
    end else if (cfg_load) begin
      state_q <= cfg_state_in;
      size_q  <= cfg_size_in;
    end
  end

  assign code_ok     = (size_q != '0) && (size_q <= SIZE_W'(MAX_CODE));
  assign swap_active = (state_q == ST_SWAP) && code_ok;

  always_comb begin
    flip_mask = '0;
    for (int k = 1; k <= MAX_CODE; k++) begin
      if (swap_active && (size_q == SIZE_W'(k)) &&
          ((cpu_addr >> (BASE_LOG2 + k)) == '0))
        flip_mask[BASE_LOG2 + k - 1] = 1'b1;
    end
  end

  assign phys_addr  = cpu_addr ^ flip_mask;
  assign stat_state = state_q;
  assign stat_size  = size_q;

  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> (stat_state == '0 && stat_size == '0));

  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (stat_state == $past(cfg_state_in) && stat_size == $past(cfg_size_in)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> ($stable(stat_state) && $stable(stat_size)));

  a_r5_above_window: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_addr >> TOP_BIT) != '0) |-> (phys_addr == cpu_addr));

  a_r6_idle_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_active |-> (phys_addr == cpu_addr));

  a_r8_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phys_addr ^ cpu_addr) <= 1);

  a_r9_active_state: assert property (@(posedge clk) disable iff (!rst_n)
    swap_active |-> (stat_state == ST_SWAP && stat_size != '0));

endmodule

// File: tb/flash_swap_remap_test.sv
`timescale 1ns/100ps
module flash_swap_remap_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [1:0]  cfg_state_in = '0;
  logic [5:0]  cfg_size_in = '0;
  logic [20:0] cpu_addr = '0;
  logic [20:0] phys_addr;
  logic [1:0]  stat_state;
  logic [5:0]  stat_size;
  logic        swap_active;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  flash_swap_remap uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_state_in(cfg_state_in), .cfg_size_in(cfg_size_in),
    .cpu_addr(cpu_addr), .phys_addr(phys_addr),
    .stat_state(stat_state), .stat_size(stat_size),
    .swap_active(swap_active)
  );

  // {state, size, cpu address, expected physical address}
  localparam int NV = 17;
  localparam logic [49:0] VEC [NV] = '{
    {2'b01, 6'd1,  21'h00000,  21'h00800},  // R3 R4
    {2'b01, 6'd1,  21'h00834,  21'h00034},  // R3
    {2'b01, 6'd1,  21'h01000,  21'h01000},  // R5
    {2'b01, 6'd2,  21'h00ABC,  21'h01ABC},  // R4
    {2'b01, 6'd2,  21'h01FFC,  21'h00FFC},  // R3
    {2'b01, 6'd2,  21'h02000,  21'h02000},  // R5
    {2'b01, 6'd3,  21'h03004,  21'h01004},  // R4
    {2'b01, 6'd6,  21'h00010,  21'h10010},  // R4
    {2'b01, 6'd6,  21'h1FFF0,  21'h0FFF0},  // R3
    {2'b01, 6'd6,  21'h20000,  21'h20000},  // R5
    {2'b01, 6'd1,  21'h1FFFFF, 21'h1FFFFF}, // R5
    {2'b11, 6'd1,  21'h00000,  21'h00000},  // R6
    {2'b00, 6'd2,  21'h00100,  21'h00100},  // R6
    {2'b10, 6'd2,  21'h01100,  21'h01100},  // R6
    {2'b01, 6'd0,  21'h00800,  21'h00800},  // R7
    {2'b01, 6'd7,  21'h00800,  21'h00800},  // R7
    {2'b01, 6'd63, 21'h00000,  21'h00000}   // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] st, input logic [5:0] sz);
    @(negedge clk);
    cfg_state_in = st;
    cfg_size_in  = sz;
    cfg_load     = 1'b1;
    @(negedge clk);
    cfg_load     = 1'b0;
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cpu_addr = 21'h00000;
    #1;
    check("R1 state", 32'(stat_state), 32'h0);
    check("R1 size", 32'(stat_size), 32'h0);
    check("R1 pass", 32'(phys_addr), 32'h0);
    check("R1 active", 32'(swap_active), 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic exp_act;
      load(VEC[i][49:48], VEC[i][47:42]);
      cpu_addr = VEC[i][41:21];
      #1;
      check($sformatf("R3/R4/R5/R6/R7 vec%0d", i), 32'(phys_addr), 32'(VEC[i][20:0]));
      check($sformatf("R8 vec%0d", i), 32'($countones(phys_addr ^ cpu_addr) <= 1), 32'h1);
      exp_act = (VEC[i][49:48] == 2'b01) && (VEC[i][47:42] >= 6'd1) && (VEC[i][47:42] <= 6'd6);
      check($sformatf("R9 vec%0d", i), 32'(swap_active), 32'(exp_act));
    end

    // R2 timing: new setting not used before the edge that captures it
    load(2'b11, 6'd1);
    cpu_addr = 21'h00000;
    @(negedge clk);
    cfg_state_in = 2'b01;
    cfg_size_in  = 6'd1;
    cfg_load     = 1'b1;
    #1;
    check("R2 before edge", 32'(phys_addr), 32'h0);
    @(negedge clk);
    cfg_load = 1'b0;
    #1;
    check("R2 after edge", 32'(phys_addr), 32'h800);
    check("R2 stat state", 32'(stat_state), 32'h1);
    check("R2 stat size", 32'(stat_size), 32'h1);

    // R2 hold: inputs change without strobe
    cfg_state_in = 2'b11;
    cfg_size_in  = 6'd5;
    repeat (3) @(negedge clk);
    #1;
    check("R2 hold state", 32'(stat_state), 32'h1);
    check("R2 hold size", 32'(stat_size), 32'h1);
    check("R2 hold remap", 32'(phys_addr), 32'h800);

    // R6 release after a swap
    load(2'b11, 6'd1);
    cpu_addr = 21'h00800;
    #1;
    check("R6 release", 32'(phys_addr), 32'h800);
    check("R6 release inactive", 32'(swap_active), 32'h0);

    // R1 reset clears an active swap
    load(2'b01, 6'd2);
    @(negedge clk);
    rst_n = 1'b0;
    cpu_addr = 21'h00004;
    #1;
    check("R1 reset state", 32'(stat_state), 32'h0);
    check("R1 reset size", 32'(stat_size), 32'h0);
    check("R1 reset pass", 32'(phys_addr), 32'h4);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule